// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit ports, A and B. Each port has its own holding register, and each register has its own clock. An active-low enable and a direction input pick which port is driven, if either one is. A separate select for each direction then decides what that port shows. It can show the live inputs of the other port, which is the pass-through path. It can also show the value held in the other port's register, which is the held path.

Each pin is modelled as three signals: an input vector, an output vector and an output-enable bit. A pad ring or a tristate wrapper can combine them. The registers load on every rising edge of their own clock, whatever the enable and direction inputs are doing. A word can therefore be captured while both ports are isolated and sent out later.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: When `rst` is high at a rising edge of `clk_ab`, the A-side register becomes 0x00. When `rst` is high at a rising edge of `clk_ba`, the B-side register becomes 0x00. The held path then shows 0x00.
- R2: On each rising edge of `clk_ab` with `rst` low, the A-side register loads `a_in`.
- R3: On each rising edge of `clk_ba` with `rst` low, the B-side register loads `b_in`.
- R4: The registers load whatever the values of `oe_n`, `dir`, `sel_ab` and `sel_ba`, including while both ports are isolated.
- R5: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R6: While `oe_n` is 0, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0.
- R7: With `sel_ab`=0, `b_out` equals `a_in` combinationally, with no clock edge needed.
- R8: With `sel_ab`=1, `b_out` equals the A-side register.
- R9: With `sel_ba`=0, `a_out` equals `b_in` combinationally.
- R10: With `sel_ba`=1, `a_out` equals the B-side register.
- R11: In held mode with the port driven, a single rising edge of the capturing clock puts the new word on the driven port. No other action is needed.
- R12: `a_oe` and `b_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Clock of the A-side register |
| clk_ba | input | 1 | Clock of the B-side register |
| rst | input | 1 | Synchronous active-high reset, sampled in each clock domain |
| oe_n | input | 1 | Active-low enable for the output drivers |
| dir | input | 1 | 1 drives port B, 0 drives port A |
| sel_ab | input | 1 | Source for B outputs: 0 live `a_in`, 1 A-side register |
| sel_ba | input | 1 | Source for A outputs: 0 live `b_in`, 1 B-side register |
| a_in | input | 8 | Value seen on the A pins |
| a_out | output | 8 | Value to put on the A pins |
| a_oe | output | 1 | Drive enable for the A pins |
| b_in | input | 8 | Value seen on the B pins |
| b_out | output | 8 | Value to put on the B pins |
| b_oe | output | 1 | Drive enable for the B pins |

## Verification
The clocked checks assume that `rst` is held high across at least one rising edge of each register clock before any comparison counts. They also assume that each register clock has a clean rising edge, with `a_in` and `b_in` stable around it. The bench meets both conditions in three ways. It changes data and controls only on the falling edge of the free-running bench clock. It makes each register clock a whole-period pulse that starts on such a falling edge. It asserts reset while pulsing both register clocks. The held-path checks also assume `a_in` did not change between two `clk_ab` edges in a way the register could miss, and the bench pulses each register clock once per loaded word.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_W = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } xfer_src_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R1
  reg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == '0);

  // R2, R3
  reg_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> q == $past(d));
endmodule

// File: rtl/xcvr_xfer_mux.sv
module xcvr_xfer_mux
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] y
);
  xfer_src_e src;

  always_comb begin
    src = xfer_src_e'(sel);
    unique case (src)
      SRC_STORED: y = held;
      default:    y = live;
    endcase
  end
endmodule

// File: rtl/xcvr_drive_decode.sv
module xcvr_drive_decode (
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);
  always_comb begin
    a_oe = 1'b0;
    b_oe = 1'b0;
    if (!oe_n) begin
      if (dir) b_oe = 1'b1;
      else     a_oe = 1'b1;
    end
  end

  // R12
  always_comb begin
    single_drive_chk: assert ($countones({a_oe, b_oe}) <= 1);
  end
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_W
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] a_held;
  logic [W-1:0] b_held;

  xcvr_capture_reg #(.W(W)) u_reg_a (
    .clk (clk_ab),
    .rst (rst),
    .d   (a_in),
    .q   (a_held)
  );

  xcvr_capture_reg #(.W(W)) u_reg_b (
    .clk (clk_ba),
    .rst (rst),
    .d   (b_in),
    .q   (b_held)
  );

  xcvr_xfer_mux #(.W(W)) u_mux_to_b (
    .sel  (sel_ab),
    .live (a_in),
    .held (a_held),
    .y    (b_out)
  );

  xcvr_xfer_mux #(.W(W)) u_mux_to_a (
    .sel  (sel_ba),
    .live (b_in),
    .held (b_held),
    .y    (a_out)
  );

  xcvr_drive_decode u_decode (
    .oe_n (oe_n),
    .dir  (dir),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

  // R5
  isolate_chk: assert property (@(posedge clk_ab) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe));

  // R11
  held_ab_chk: assert property (@(posedge clk_ab) disable iff (rst)
    (!$past(rst) && b_oe && sel_ab) |-> b_out == $past(a_in));

  // R11
  held_ba_chk: assert property (@(posedge clk_ba) disable iff (rst)
    (!$past(rst) && a_oe && sel_ba) |-> a_out == $past(b_in));
endmodule

// File: tb/bidir_reg_xcvr_tb.sv
module bidir_reg_xcvr_tb;
  localparam int W = 8;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  int checks = 0, failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bidir_reg_xcvr #(.W(W)) u_dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // {oe_n, dir, sel_ab, sel_ba, a_in, b_in, a_oe, b_oe, a_out exp, b_out exp}
  // Registers preloaded: A = 0x5A, B = 0xC3
  localparam logic [37:0] VEC [NV] = '{
    {4'b1000, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},  // R5
    {4'b1111, 8'h33, 8'h44, 2'b00, 8'h00, 8'h00},  // R5
    {4'b0100, 8'hA1, 8'hB2, 2'b01, 8'h00, 8'hA1},  // R6 R7
    {4'b0110, 8'hA1, 8'hB2, 2'b01, 8'h00, 8'h5A},  // R8
    {4'b0000, 8'hA1, 8'hB2, 2'b10, 8'hB2, 8'h00},  // R6 R9
    {4'b0001, 8'hA1, 8'hB2, 2'b10, 8'hC3, 8'h00},  // R10
    {4'b0010, 8'h0F, 8'hF0, 2'b10, 8'hF0, 8'h00},  // R9
    {4'b0101, 8'h0F, 8'hF0, 2'b01, 8'h00, 8'h0F}   // R7
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    @(negedge clk); clk_ab = 1'b1;
    @(negedge clk); clk_ab = 1'b0;
  endtask

  task automatic pulse_ba();
    @(negedge clk); clk_ba = 1'b1;
    @(negedge clk); clk_ba = 1'b0;
  endtask

  task automatic ctl(input logic on, input logic d, input logic sa, input logic sb);
    @(negedge clk);
    oe_n = on; dir = d; sel_ab = sa; sel_ba = sb;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    rst = 1'b1;
    pulse_ab();
    pulse_ba();
    @(negedge clk); rst = 1'b0;
    ctl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1 A reg after reset", b_out, 8'h00);
    ctl(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1 B reg after reset", a_out, 8'h00);

    // Preload while isolated (R4)
    ctl(1'b1, 1'b0, 1'b0, 1'b0);
    a_in = 8'h5A; pulse_ab();
    b_in = 8'hC3; pulse_ba();

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      @(negedge clk);
      {oe_n, dir, sel_ab, sel_ba} = v[37:34];
      a_in = v[33:26];
      b_in = v[25:18];
      #1;
      chk("R5 R6 a_oe", {7'd0, a_oe}, {7'd0, v[17]});
      chk("R5 R6 b_oe", {7'd0, b_oe}, {7'd0, v[16]});
      chk("R12 one enable", {6'd0, a_oe, b_oe} & {6'd0, b_oe, a_oe}, 8'h00);
      if (v[17]) chk("R9 R10 a_out", a_out, v[15:8]);
      if (v[16]) chk("R7 R8 b_out", b_out, v[7:0]);
    end

    // R7 transparent follows without clock, register untouched
    ctl(1'b0, 1'b1, 1'b0, 1'b0);
    a_in = 8'h3C; #1;
    chk("R7 live follow", b_out, 8'h3C);
    ctl(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R2 reg unchanged without edge", b_out, 8'h5A);

    // R11 A to B held: one edge loads and shows
    a_in = 8'h77;
    pulse_ab(); #1;
    chk("R11 R2 held A to B", b_out, 8'h77);

    // R11 B to A held
    ctl(1'b0, 1'b0, 1'b0, 1'b1);
    b_in = 8'h99;
    pulse_ba(); #1;
    chk("R11 R3 held B to A", a_out, 8'h99);

    // R4 capture while isolated, with odd controls
    ctl(1'b1, 1'b1, 1'b0, 1'b0);
    a_in = 8'hE7; pulse_ab();
    b_in = 8'h18; pulse_ba();
    a_in = 8'h00; b_in = 8'h00;
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R4 A captured while isolated", b_out, 8'hE7);
    ctl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 B captured while isolated", a_out, 8'h18);

    // R3 independent clocks: clk_ab edge leaves B register alone
    b_in = 8'h42; pulse_ab(); #1;
    chk("R3 B reg ignores clk_ab", a_out, 8'h18);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    pulse_ab(); pulse_ba();
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 B reg cleared", a_out, 8'h00);
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R1 A reg cleared", b_out, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule